// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, A and B, through a pair of open-drain style ports. Each direction has its own storage register and its own capture strobe. A rising edge on the A-to-B strobe stores the A bus. A rising edge on the B-to-A strobe stores the B bus. For the bus being driven, a per-direction source select picks either the live value of the opposite bus or the value held in that direction's register. An active-low output enable and a direction input decide which bus is driven, if any.

Neither port drives a high level. Each bit exposes a pull-low enable, and the high level comes from an external pull-up. The block takes the raw external level of each bus as an input. The line it stores is the resolved line, that is, the external level ANDed with the inverse of its own pull-low. Storage is always armed, so data can be captured and later replayed while both ports are isolated. A parameter selects between a non-inverting and an inverting data path.

All pins are plain levels with no handshake. The block has no back-pressure of any kind: a capture strobe edge always stores. The pull-low outputs follow their inputs combinationally, with no added latency. The strobes are sampled on the block clock, so a strobe edge stores on the first clock edge at which the strobe is seen high after being low.

Top module: `regbus_xcvr`

## Requirements
- R1: After a synchronous active-low reset, both storage registers hold all zeros. In stored mode this is visible as the driven port pulling every bit low (non-inverting) or no bit (inverting).
- R2: While `oe_n_i` is 1, both `a_pull_o` and `b_pull_o` are all zeros, whatever the other controls are.
- R3: While `oe_n_i` is 0, `dir_ab_i`=1 drives only B, with `a_pull_o`=0, and `dir_ab_i`=0 drives only A, with `b_pull_o`=0. The select of the undriven direction has no effect on the outputs.
- R4: When B is driven and `ab_src_i`=0, B carries the live A bus. In the non-inverting build, bit i of `b_pull_o` is 1 exactly when bit i of `a_in_i` is 0.
- R5: When B is driven and `ab_src_i`=1, B carries the stored A register. The pull-low rule is the same as in R4.
- R6: When A is driven, `ba_src_i` works for A the same way: 0 selects the live B bus and 1 selects the stored B register.
- R7: A register loads only on a 0-to-1 transition of its capture strobe, seen at a clock edge. Holding the strobe high, or changing the data while the strobe is low, leaves the register unchanged.
- R8: Captures happen whatever the values of `oe_n_i` and `dir_ab_i`, including during isolation.
- R9: The value stored from a bus is the resolved line, that is, the external input ANDed with the inverse of the block's own pull-low on that bus.
- R10: With `INVERT`=1, the driven value is the complement of the selected live or stored value. A bit is then pulled low when the selected bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n_i | input | 1 | Output enable, active low; 1 isolates both ports |
| dir_ab_i | input | 1 | 1 drives B from the A path, 0 drives A from the B path |
| ab_src_i | input | 1 | A-to-B source: 0 live A bus, 1 stored A register |
| ba_src_i | input | 1 | B-to-A source: 0 live B bus, 1 stored B register |
| ab_cap_i | input | 1 | A-to-B capture strobe; a rising transition stores the A bus |
| ba_cap_i | input | 1 | B-to-A capture strobe; a rising transition stores the B bus |
| a_in_i | input | WIDTH | External level of the A bus |
| b_in_i | input | WIDTH | External level of the B bus |
| a_pull_o | output | WIDTH | Per-bit pull-low enable for the A bus |
| b_pull_o | output | WIDTH | Per-bit pull-low enable for the B bus |

## Verification
The output mux is exercised with a vector table that walks isolation, both directions and both source selects. The data patterns are chosen so that live, stored and complemented values all differ, which tells a wrong source or wrong direction apart from a correct one. Directed sequences then check the following:
- a strobe held high, and data changed while the strobe is low, does not cause a reload;
- captures made during isolation are kept;
- a capture taken while the block itself pulls the bus stores the resolved line and not the raw input.

A second instance built with inversion runs alongside, so that polarity errors show up against the non-inverting expectations.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

  // Source chosen for a driven port.
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  // Per-direction control decoded from the mode pins.
  typedef struct packed {
    logic     drive;
    src_sel_e src;
  } path_ctrl_t;

  // Direction indices used by the generate loop in the top.
  localparam int unsigned PATH_AB = 0;
  localparam int unsigned PATH_BA = 1;
  localparam int unsigned NUM_PATHS = 2;

endpackage

// File: rtl/regbus_xcvr_rise_det.sv
module regbus_xcvr_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~prev_q;
endmodule

// File: rtl/regbus_xcvr_store.sv
module regbus_xcvr_store #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk) begin
    if (!rst_n)      q_r <= '0;
    else if (load_i) q_r <= d_i;
  end

  assign q_o = q_r;
endmodule

// File: rtl/regbus_xcvr_ctrl.sv
module regbus_xcvr_ctrl
  import regbus_xcvr_pkg::*;
(
  input  logic       oe_n_i,
  input  logic       dir_ab_i,
  input  logic       ab_src_i,
  input  logic       ba_src_i,
  output path_ctrl_t ab_ctrl_o,
  output path_ctrl_t ba_ctrl_o
);
  logic enabled;

  always_comb begin
    enabled         = ~oe_n_i;
    ab_ctrl_o.drive = enabled &  dir_ab_i;
    ba_ctrl_o.drive = enabled & ~dir_ab_i;
    ab_ctrl_o.src   = ab_src_i ? SRC_STORED : SRC_LIVE;
    ba_ctrl_o.src   = ba_src_i ? SRC_STORED : SRC_LIVE;
  end
endmodule

// File: rtl/regbus_xcvr_drive.sv
module regbus_xcvr_drive
  import regbus_xcvr_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter bit          INVERT = 1'b0
) (
  input  path_ctrl_t       ctrl_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  output logic [WIDTH-1:0] pull_o
);
  logic [WIDTH-1:0] picked;
  logic [WIDTH-1:0] level;

  always_comb begin
    picked = (ctrl_i.src == SRC_STORED) ? stored_i : live_i;
  end

  generate
    if (INVERT) begin : g_inv
      assign level = ~picked;
    end else begin : g_pass
      assign level = picked;
    end
  endgenerate

  // Open-drain: a driven bit whose level is 0 pulls the line low.
  assign pull_o = {WIDTH{ctrl_i.drive}} & ~level;
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter bit          INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_n_i,
  input  logic             dir_ab_i,
  input  logic             ab_src_i,
  input  logic             ba_src_i,
  input  logic             ab_cap_i,
  input  logic             ba_cap_i,
  input  logic [WIDTH-1:0] a_in_i,
  input  logic [WIDTH-1:0] b_in_i,
  output logic [WIDTH-1:0] a_pull_o,
  output logic [WIDTH-1:0] b_pull_o
);
  path_ctrl_t       ctrl   [NUM_PATHS];
  logic             strobe [NUM_PATHS];
  logic [WIDTH-1:0] live   [NUM_PATHS];
  logic [WIDTH-1:0] line   [NUM_PATHS];
  logic [WIDTH-1:0] stored [NUM_PATHS];
  logic [WIDTH-1:0] pull   [NUM_PATHS];

  regbus_xcvr_ctrl u_ctrl (
    .oe_n_i    (oe_n_i),
    .dir_ab_i  (dir_ab_i),
    .ab_src_i  (ab_src_i),
    .ba_src_i  (ba_src_i),
    .ab_ctrl_o (ctrl[PATH_AB]),
    .ba_ctrl_o (ctrl[PATH_BA])
  );

  // The live input of a path is its source bus's raw level: that bus is
  // never driven while the path drives, so raw equals resolved and no
  // combinational loop through the opposite port exists.
  assign strobe[PATH_AB] = ab_cap_i;
  assign strobe[PATH_BA] = ba_cap_i;
  assign live[PATH_AB]   = a_in_i;
  assign live[PATH_BA]   = b_in_i;
  // Capture data is the resolved line, including this block's own pull.
  assign line[PATH_AB]   = a_in_i & ~pull[PATH_BA];
  assign line[PATH_BA]   = b_in_i & ~pull[PATH_AB];

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic load;

    regbus_xcvr_rise_det u_rise (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe[p]),
      .rise_o   (load)
    );

    regbus_xcvr_store #(.WIDTH(WIDTH)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .d_i    (line[p]),
      .q_o    (stored[p])
    );

    regbus_xcvr_drive #(.WIDTH(WIDTH), .INVERT(INVERT)) u_drive (
      .ctrl_i   (ctrl[p]),
      .live_i   (live[p]),
      .stored_i (stored[p]),
      .pull_o   (pull[p])
    );
  end

  assign b_pull_o = pull[PATH_AB];
  assign a_pull_o = pull[PATH_BA];
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int unsigned WIDTH  = 8,
  parameter bit          INVERT = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n_i,
  input logic             dir_ab_i,
  input logic             ab_src_i,
  input logic             ba_src_i,
  input logic             ab_cap_i,
  input logic             ba_cap_i,
  input logic [WIDTH-1:0] a_pull_o,
  input logic [WIDTH-1:0] b_pull_o
);
  logic ab_stored_mode;
  logic ba_stored_mode;
  logic [WIDTH-1:0] reset_view;

  assign ab_stored_mode = !oe_n_i &&  dir_ab_i && ab_src_i;
  assign ba_stored_mode = !oe_n_i && !dir_ab_i && ba_src_i;
  assign reset_view     = {WIDTH{INVERT == 1'b0}};

  // R1: a cleared register shows up in stored mode on the first cycle out of reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && ab_stored_mode) |-> (b_pull_o == reset_view));

  // R2: isolation releases both ports
  a_r2_isolation: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> (a_pull_o == '0 && b_pull_o == '0));

  // R3: never both ports pulled, and the undriven side stays released
  a_r3_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    (a_pull_o == '0) || (b_pull_o == '0));

  a_r3_dir_release: assert property (@(posedge clk) disable iff (!rst_n)
    dir_ab_i |-> (a_pull_o == '0));

  // R7: no strobe rise, no change in the replayed A register
  a_r7_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ab_stored_mode && !(ab_cap_i && !$past(ab_cap_i)))
      |=> (!ab_stored_mode || $stable(b_pull_o)));

  // R7: same for the B register replayed onto A
  a_r7_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ba_stored_mode && !(ba_cap_i && !$past(ba_cap_i)))
      |=> (!ba_stored_mode || $stable(a_pull_o)));
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .oe_n_i   (oe_n_i),
  .dir_ab_i (dir_ab_i),
  .ab_src_i (ab_src_i),
  .ba_src_i (ba_src_i),
  .ab_cap_i (ab_cap_i),
  .ba_cap_i (ba_cap_i),
  .a_pull_o (a_pull_o),
  .b_pull_o (b_pull_o)
);

// File: tb/regbus_xcvr_tb.sv
`timescale 1ns/1ps
module regbus_xcvr_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic oe_n, dir_ab, ab_src, ba_src, ab_cap, ba_cap;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_pull, b_pull, a_pull_i, b_pull_i;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regbus_xcvr #(.WIDTH(W), .INVERT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .oe_n_i(oe_n), .dir_ab_i(dir_ab),
    .ab_src_i(ab_src), .ba_src_i(ba_src), .ab_cap_i(ab_cap), .ba_cap_i(ba_cap),
    .a_in_i(a_in), .b_in_i(b_in), .a_pull_o(a_pull), .b_pull_o(b_pull));

  regbus_xcvr #(.WIDTH(W), .INVERT(1'b1)) u_dut_inv (
    .clk(clk), .rst_n(rst_n), .oe_n_i(oe_n), .dir_ab_i(dir_ab),
    .ab_src_i(ab_src), .ba_src_i(ba_src), .ab_cap_i(ab_cap), .ba_cap_i(ba_cap),
    .a_in_i(a_in), .b_in_i(b_in), .a_pull_o(a_pull_i), .b_pull_o(b_pull_i));

  // Vector: {oe_n, dir, ab_src, ba_src, a_in, b_in, exp_a_pull, exp_b_pull}
  // Stored A = A5, stored B = 3C when the table runs (non-inverting DUT).
  localparam int NV = 9;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 8'hF0, 8'h0F, 8'h00, 8'h00},  // R2
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'h00, 8'h00},  // R2
    {1'b0, 1'b1, 1'b0, 1'b0, 8'hF0, 8'hFF, 8'h00, 8'h0F},  // R4
    {1'b0, 1'b1, 1'b0, 1'b1, 8'h81, 8'hFF, 8'h00, 8'h7E},  // R4, R3
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 8'h00, 8'h5A},  // R5
    {1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hC3, 8'h3C, 8'h00},  // R6
    {1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, 8'hC3, 8'h00},  // R6
    {1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h12, 8'hC3, 8'h00},  // R3
    {1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h5A}   // R3
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic o, input logic d, input logic sab, input logic sba);
    oe_n = o; dir_ab = d; ab_src = sab; ba_src = sba;
  endtask

  task automatic pulse_ab();
    @(negedge clk); ab_cap = 1'b1;
    @(negedge clk); ab_cap = 1'b0;
  endtask

  task automatic pulse_ba();
    @(negedge clk); ba_cap = 1'b1;
    @(negedge clk); ba_cap = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; set_mode(1'b1, 1'b0, 1'b0, 1'b0);
    ab_cap = 1'b0; ba_cap = 1'b0; a_in = '1; b_in = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: registers cleared, seen through stored mode on both ports
    @(negedge clk); set_mode(1'b0, 1'b1, 1'b1, 1'b1); #1;
    check("R1 stored A after reset", b_pull, 8'hFF);
    check("R1 stored A after reset inv", b_pull_i, 8'h00);
    set_mode(1'b0, 1'b0, 1'b1, 1'b1); #1;
    check("R1 stored B after reset", a_pull, 8'hFF);

    // R8: load both registers while isolated
    set_mode(1'b1, 1'b1, 1'b1, 1'b1);
    a_in = 8'hA5; b_in = 8'h3C;
    pulse_ab();
    pulse_ba();
    #1;
    check("R8 isolated during capture", a_pull | b_pull, 8'h00);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {oe_n, dir_ab, ab_src, ba_src, a_in, b_in} = VEC[i][35:16];
      #1;
      check($sformatf("R2-R6 vec%0d a_pull", i), a_pull, VEC[i][15:8]);
      check($sformatf("R2-R6 vec%0d b_pull", i), b_pull, VEC[i][7:0]);
    end
    // R8: stored values from the isolated capture were checked by vectors 4 and 6

    // R10: inverting build
    @(negedge clk); set_mode(1'b0, 1'b1, 1'b0, 1'b0); a_in = 8'hF0; b_in = 8'hFF; #1;
    check("R10 inverted live A to B", b_pull_i, 8'hF0);
    set_mode(1'b0, 1'b1, 1'b1, 1'b0); #1;
    check("R10 inverted stored A to B", b_pull_i, 8'hA5);
    set_mode(1'b0, 1'b0, 1'b0, 1'b1); #1;
    check("R10 inverted stored B to A", a_pull_i, 8'h3C);

    // R9: capture A while A is pulled by replaying stored B (3C)
    a_in = 8'hFF;
    pulse_ab();
    @(negedge clk); set_mode(1'b0, 1'b1, 1'b1, 1'b0); #1;
    check("R9 resolved capture", b_pull, 8'hC3);
    check("R9 resolved capture inv", b_pull_i, 8'hC3);

    // R7: held strobe and data changes while low do not reload
    @(negedge clk); a_in = 8'h11; ab_cap = 1'b1;
    @(negedge clk); a_in = 8'h77;
    repeat (2) @(negedge clk);
    #1;
    check("R7 held strobe", b_pull, 8'hEE);
    ab_cap = 1'b0; a_in = 8'h99;
    repeat (2) @(negedge clk);
    #1;
    check("R7 data change strobe low", b_pull, 8'hEE);
    ab_cap = 1'b1;
    @(negedge clk); ab_cap = 1'b0; #1;
    check("R7 new rise reloads", b_pull, 8'h66);

    // R3: B-to-A select ignored when B driven
    ba_src = 1'b0; b_in = 8'h00; #1;
    check("R3 ba select ignored", a_pull, 8'h00);
    check("R3 b still stored", b_pull, 8'h66);

    // R2: isolation after activity
    oe_n = 1'b1; #1;
    check("R2 isolation", b_pull | a_pull, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule